// File: doc/BRIEF.md
# Faulty-Block Column Remap Table

This block sits beside the row decoder of a cache that has been shrunk around defective storage blocks. It keeps a small fully associative table. Each entry pairs the cache index of one block known to be bad with the column number of a healthy block in the same row. Every cache access presents its index, and the table compares it against all live entries at once. On a match, the block raises a hit flag and drives the stored substitute column, which the cache uses in place of its own column select. On a miss, the column bits of the presented index pass through untouched.

Entries are loaded only while the cache is being tested or configured. Each load goes into the next unused slot. A full flag shows that no slot remains, and loads beyond that are dropped. A clear input empties the whole table, so a fresh test pass can start after the supply or clock conditions change. Finding the faults and choosing the substitute blocks are done elsewhere. The table depth, index width, column width and output timing are parameters.

Top module: `fault_cam_remap`

## Requirements
- R1: A synchronous active-high `rst` empties the table. After it, `full`, `lk_hit` and `lk_col` read 0.
- R2: Each accepted pulse on `cfg_we` stores the pair (`cfg_idx`, `cfg_col`) in the next unused slot. A later lookup of that index hits and returns that column.
- R3: A lookup compares against every live slot in parallel, so the first, a middle and the last filled slot all hit alike.
- R4: On a miss, `lk_hit` is 0 and `lk_col` equals the column field of the looked-up index, which is bits [COL_W-1:0] of `lk_idx`.
- R5: On a hit, `lk_hit` is 1 and `lk_col` carries the stored substitute column, even when that differs from the index's own column field.
- R6: With `REG_OUT`=1 (the default), the result for an index applied before a rising edge appears after that edge. A load taken at the same edge is not yet visible to that lookup; it is visible to the next one.
- R7: `full` rises once DEPTH loads have been accepted, and stays high until `clr` or `rst`.
- R8: A load while `full` is high is ignored: the table is unchanged, and a lookup of the dropped index misses.
- R9: `clr` invalidates every slot and restarts filling from the first slot. It wins over a load in the same cycle, which is dropped. After the clear, `full` is 0 and earlier indices miss.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clr | input | 1 | Invalidate all slots and restart filling |
| cfg_we | input | 1 | Load one pair into the next unused slot |
| cfg_idx | input | IDX_W | Cache index of the faulty block to load |
| cfg_col | input | COL_W | Substitute column for that index |
| lk_idx | input | IDX_W | Index of the current cache access |
| lk_hit | output | 1 | The index matched a live slot |
| lk_col | output | COL_W | Column the cache should select |
| full | output | 1 | No unused slot remains |

## Verification
The bench fills the table to the last slot and checks that hits at the first, a middle and the last position all return the right column. A design with an off-by-one fill pointer would lose the edge slot or flag full one load early. It sends a load and a lookup of the same index in the same cycle and expects a miss followed by a hit; a design that forwarded the write would hit too early. It loads past full and then looks up the dropped index; a design that wrapped its pointer would overwrite the first slot and hit. It also raises a clear together with a load and expects every earlier index and the dropped one to miss; a design that let the load win would keep a live slot after the clear.

// File: rtl/fcam_pkg.sv
package fcam_pkg;

  // Output timing of the lookup path
  typedef enum logic {
    LK_COMB = 1'b0,
    LK_REG  = 1'b1
  } lk_mode_e;

  // Width of a counter that must reach the value d
  function automatic int unsigned cnt_width(input int unsigned d);
    return $clog2(d + 1);
  endfunction

  // Width of a pointer that addresses d slots (at least 1)
  function automatic int unsigned ptr_width(input int unsigned d);
    return (d > 1) ? $clog2(d) : 1;
  endfunction

endpackage

// File: rtl/fcam_fill_ctrl.sv
module fcam_fill_ctrl #(
  parameter int unsigned DEPTH = 128,
  localparam int unsigned CNT_W = fcam_pkg::cnt_width(DEPTH),
  localparam int unsigned PTR_W = fcam_pkg::ptr_width(DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             we,
  output logic             wr_go,
  output logic [PTR_W-1:0] wr_ptr,
  output logic             full
);

  localparam logic [CNT_W-1:0] LAST = CNT_W'(DEPTH);

  logic [CNT_W-1:0] used_q;

  // full is decoded straight from the registered fill count
  assign full   = (used_q == LAST);
  assign wr_go  = we && !clr && !full;
  assign wr_ptr = used_q[PTR_W-1:0];

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      used_q <= '0;
    end else if (wr_go) begin
      used_q <= used_q + 1'b1;
    end
  end

endmodule

// File: rtl/fcam_entry_array.sv
module fcam_entry_array #(
  parameter int unsigned DEPTH = 128,
  parameter int unsigned IDX_W = 11,
  parameter int unsigned COL_W = 2,
  localparam int unsigned PTR_W = fcam_pkg::ptr_width(DEPTH)
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        clr,
  input  logic                        wr_go,
  input  logic [PTR_W-1:0]            wr_ptr,
  input  logic [IDX_W-1:0]            wr_idx,
  input  logic [COL_W-1:0]            wr_col,
  input  logic [IDX_W-1:0]            lk_idx,
  output logic [DEPTH-1:0]            hit_line,
  output logic [DEPTH-1:0][COL_W-1:0] slot_col
);

  logic [DEPTH-1:0] live_q;

  // Valid bits carry the reset; payload registers do not
  always_ff @(posedge clk) begin
    if (rst || clr) begin
      live_q <= '0;
    end else if (wr_go) begin
      live_q[wr_ptr] <= 1'b1;
    end
  end

  for (genvar s = 0; s < DEPTH; s++) begin : g_slot
    logic [IDX_W-1:0] key_q;
    logic [COL_W-1:0] sub_q;

    always_ff @(posedge clk) begin
      if (wr_go && (wr_ptr == PTR_W'(s))) begin
        key_q <= wr_idx;
        sub_q <= wr_col;
      end
    end

    assign hit_line[s] = live_q[s] && (key_q == lk_idx);
    assign slot_col[s] = sub_q;
  end

endmodule

// File: rtl/fcam_hit_mux.sv
module fcam_hit_mux #(
  parameter int unsigned DEPTH = 128,
  parameter int unsigned COL_W = 2,
  parameter fcam_pkg::lk_mode_e MODE = fcam_pkg::LK_REG
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [DEPTH-1:0]            hit_line,
  input  logic [DEPTH-1:0][COL_W-1:0] slot_col,
  input  logic [COL_W-1:0]            dflt_col,
  output logic                        hit,
  output logic [COL_W-1:0]            col
);

  logic             any_d;
  logic [COL_W-1:0] pick_d;
  logic [COL_W-1:0] col_d;

  // One-hot AND-OR select: a valid table has at most one hit line high
  always_comb begin
    pick_d = '0;
    for (int s = 0; s < DEPTH; s++) begin
      pick_d = pick_d | (slot_col[s] & {COL_W{hit_line[s]}});
    end
  end

  assign any_d = |hit_line;
  assign col_d = any_d ? pick_d : dflt_col;

  if (MODE == fcam_pkg::LK_REG) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst) begin
        hit <= 1'b0;
        col <= '0;
      end else begin
        hit <= any_d;
        col <= col_d;
      end
    end
  end else begin : g_comb
    assign hit = any_d;
    assign col = col_d;
  end

endmodule

// File: rtl/fault_cam_remap.sv
module fault_cam_remap #(
  parameter int unsigned DEPTH   = 128,
  parameter int unsigned IDX_W   = 11,
  parameter int unsigned COL_W   = 2,
  parameter bit          REG_OUT = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             cfg_we,
  input  logic [IDX_W-1:0] cfg_idx,
  input  logic [COL_W-1:0] cfg_col,
  input  logic [IDX_W-1:0] lk_idx,
  output logic             lk_hit,
  output logic [COL_W-1:0] lk_col,
  output logic             full
);

  localparam int unsigned PTR_W = fcam_pkg::ptr_width(DEPTH);
  localparam fcam_pkg::lk_mode_e MODE =
    REG_OUT ? fcam_pkg::LK_REG : fcam_pkg::LK_COMB;

  logic                        wr_go;
  logic [PTR_W-1:0]            wr_ptr;
  logic [DEPTH-1:0]            hit_line;
  logic [DEPTH-1:0][COL_W-1:0] slot_col;

  fcam_fill_ctrl #(
    .DEPTH (DEPTH)
  ) u_fill (
    .clk    (clk),
    .rst    (rst),
    .clr    (clr),
    .we     (cfg_we),
    .wr_go  (wr_go),
    .wr_ptr (wr_ptr),
    .full   (full)
  );

  fcam_entry_array #(
    .DEPTH (DEPTH),
    .IDX_W (IDX_W),
    .COL_W (COL_W)
  ) u_array (
    .clk      (clk),
    .rst      (rst),
    .clr      (clr),
    .wr_go    (wr_go),
    .wr_ptr   (wr_ptr),
    .wr_idx   (cfg_idx),
    .wr_col   (cfg_col),
    .lk_idx   (lk_idx),
    .hit_line (hit_line),
    .slot_col (slot_col)
  );

  fcam_hit_mux #(
    .DEPTH (DEPTH),
    .COL_W (COL_W),
    .MODE  (MODE)
  ) u_mux (
    .clk      (clk),
    .rst      (rst),
    .hit_line (hit_line),
    .slot_col (slot_col),
    .dflt_col (lk_idx[COL_W-1:0]),
    .hit      (lk_hit),
    .col      (lk_col)
  );

endmodule

// File: rtl/fcam_checker.sv
module fcam_checker #(
  parameter int unsigned IDX_W   = 11,
  parameter int unsigned COL_W   = 2,
  parameter bit          REG_OUT = 1'b1
) (
  input logic             clk,
  input logic             rst,
  input logic             clr,
  input logic             cfg_we,
  input logic [IDX_W-1:0] lk_idx,
  input logic             lk_hit,
  input logic [COL_W-1:0] lk_col,
  input logic             full
);

  // Set once a clock edge has passed with reset low
  logic up_q;
  always_ff @(posedge clk) begin
    if (rst) up_q <= 1'b0;
    else     up_q <= 1'b1;
  end

  // R9: clearing leaves free slots
  p_clear_frees_r9: assert property (@(posedge clk) disable iff (rst)
    clr |=> !full);

  // R7: full holds until a clear
  p_full_sticky_r7: assert property (@(posedge clk) disable iff (rst)
    full && !clr |=> full);

  // R2: full only rises after an accepted load
  p_full_needs_load_r2: assert property (@(posedge clk) disable iff (rst)
    up_q && $rose(full) |-> $past(cfg_we));

  if (REG_OUT) begin : g_reg_chk
    // R4: a miss passes the column field of the index through
    p_miss_pass_r4: assert property (@(posedge clk) disable iff (rst)
      up_q && !lk_hit |-> lk_col == $past(lk_idx[COL_W-1:0]));
    // R9: first lookup after a clear sees an empty table
    p_empty_after_clr_r9: assert property (@(posedge clk) disable iff (rst)
      clr |=> ##1 !lk_hit);
  end else begin : g_comb_chk
    p_miss_pass_r4: assert property (@(posedge clk) disable iff (rst)
      !lk_hit |-> lk_col == lk_idx[COL_W-1:0]);
    p_empty_after_clr_r9: assert property (@(posedge clk) disable iff (rst)
      clr |=> !lk_hit);
  end

endmodule

bind fault_cam_remap fcam_checker #(
  .IDX_W   (IDX_W),
  .COL_W   (COL_W),
  .REG_OUT (REG_OUT)
) u_chk (
  .clk    (clk),
  .rst    (rst),
  .clr    (clr),
  .cfg_we (cfg_we),
  .lk_idx (lk_idx),
  .lk_hit (lk_hit),
  .lk_col (lk_col),
  .full   (full)
);

// File: tb/fault_cam_remap_tb.sv
`timescale 1ns/1ps
module fault_cam_remap_tb;

  localparam int DEPTH = 128;
  localparam int IDX_W = 11;
  localparam int COL_W = 2;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             clr = 1'b0;
  logic             cfg_we = 1'b0;
  logic [IDX_W-1:0] cfg_idx = '0;
  logic [COL_W-1:0] cfg_col = '0;
  logic [IDX_W-1:0] lk_idx = '0;
  logic             lk_hit;
  logic [COL_W-1:0] lk_col;
  logic             full;

  always #5 clk = ~clk;

  fault_cam_remap #(.DEPTH(DEPTH), .IDX_W(IDX_W), .COL_W(COL_W)) u_dut (
    .clk(clk), .rst(rst), .clr(clr), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
    .cfg_col(cfg_col), .lk_idx(lk_idx), .lk_hit(lk_hit), .lk_col(lk_col),
    .full(full)
  );

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  bit done   = 0;

  // Behavioural reference: queues of loaded pairs
  logic [IDX_W-1:0] m_idx[$];
  logic [COL_W-1:0] m_col[$];
  logic             e_hit = 1'b0;
  logic [COL_W-1:0] e_col = '0;
  logic             e_full = 1'b0;

  always @(posedge clk) begin
    cycles++;
    if (rst) begin
      m_idx.delete(); m_col.delete();
      e_hit = 1'b0; e_col = '0;
    end else begin
      e_hit = 1'b0;
      e_col = lk_idx[COL_W-1:0];
      foreach (m_idx[i]) if (m_idx[i] == lk_idx) begin e_hit = 1'b1; e_col = m_col[i]; end
      if (clr) begin
        m_idx.delete(); m_col.delete();
      end else if (cfg_we && m_idx.size() < DEPTH) begin
        m_idx.push_back(cfg_idx); m_col.push_back(cfg_col);
      end
    end
    e_full = (m_idx.size() == DEPTH);
  end

  // Per-cycle comparison against the model, away from the active edge
  always @(negedge clk) begin
    if (cycles > 0 && !done) begin
      checks++;
      if (lk_hit !== e_hit || lk_col !== e_col) begin
        fails++;
        $display("FAIL %s model lookup: hit=%0b col=%0d expected hit=%0b col=%0d",
                 e_hit ? "R5" : "R4", lk_hit, lk_col, e_hit, e_col);
      end
      checks++;
      if (full !== e_full) begin
        fails++;
        $display("FAIL R7 model full: got %0b expected %0b", full, e_full);
      end
    end
  end

  function automatic logic [IDX_W-1:0] key_of(input int k);
    return IDX_W'((k * 37 + 5) % (1 << IDX_W));
  endfunction
  function automatic logic [COL_W-1:0] sub_of(input int k);
    logic [IDX_W-1:0] x;
    x = key_of(k);
    return x[COL_W-1:0] ^ COL_W'(1);
  endfunction

  task automatic check(input string tag, input logic [COL_W+1:0] got,
                       input logic [COL_W+1:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got {full,hit,col}=%b expected %b", tag, got, exp);
    end
  endtask

  task automatic drive(input logic c, input logic we, input int k, input logic [IDX_W-1:0] li);
    @(negedge clk);
    clr = c; cfg_we = we; cfg_idx = key_of(k); cfg_col = sub_of(k); lk_idx = li;
  endtask

  // Look up, then sample after the registered output updates
  task automatic look(input string tag, input logic [IDX_W-1:0] li,
                      input logic h, input logic [COL_W-1:0] c, input logic f);
    drive(1'b0, 1'b0, 0, li);
    @(negedge clk);
    check(tag, {f, h, lk_col}, {f, h, c});
    check(tag, {full, lk_hit, lk_col}, {f, h, c});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    check("R1 reset state", {full, lk_hit, lk_col}, '0);
    // R4: empty table passes the column field through
    look("R4 miss on empty", 11'h106, 1'b0, 2'd2, 1'b0);
    // R2: fill the first slots
    for (int k = 0; k < 5; k++) drive(1'b0, 1'b1, k, '0);
    look("R2 stored pair hits", key_of(2), 1'b1, sub_of(2), 1'b0);
    // R6: load and lookup of the same index in one cycle
    drive(1'b0, 1'b1, 5, key_of(5));
    drive(1'b0, 1'b0, 0, key_of(5));
    check("R6 same-cycle load not visible", {lk_hit, lk_col}, {1'b0, key_of(5)[COL_W-1:0]});
    @(negedge clk);
    check("R6 load visible next lookup", {lk_hit, lk_col}, {1'b1, sub_of(5)});
    // fill to the last slot
    for (int k = 6; k < DEPTH; k++) drive(1'b0, 1'b1, k, key_of(k - 1));
    drive(1'b0, 1'b0, 0, '0);
    @(negedge clk);
    check("R7 full after DEPTH loads", {full, 2'b0, 1'b0}, {1'b1, 2'b0, 1'b0});
    // R8: load while full is dropped
    drive(1'b0, 1'b1, 300, '0);
    look("R8 dropped index misses", key_of(300), 1'b0, key_of(300)[COL_W-1:0], 1'b1);
    // R3: first, middle and last slot
    look("R3 first slot", key_of(0), 1'b1, sub_of(0), 1'b1);
    look("R3 middle slot", key_of(DEPTH / 2), 1'b1, sub_of(DEPTH / 2), 1'b1);
    look("R3 last slot", key_of(DEPTH - 1), 1'b1, sub_of(DEPTH - 1), 1'b1);
    // R5: override differs from the index column field
    look("R5 override column", key_of(77), 1'b1, sub_of(77), 1'b1);
    // lookups of many indices, compared by the model every cycle
    for (int k = 0; k < 400; k++) drive(1'b0, 1'b0, 0, key_of((k * 13) % (2 * DEPTH)));
    // R9: clear with a same-cycle load
    drive(1'b1, 1'b1, 400, '0);
    drive(1'b0, 1'b0, 0, key_of(400));
    @(negedge clk);
    check("R9 clear wins over load", {full, lk_hit, lk_col}, {2'b00, key_of(400)[COL_W-1:0]});
    look("R9 old entry misses", key_of(3), 1'b0, key_of(3)[COL_W-1:0], 1'b0);
    drive(1'b0, 1'b1, 9, '0);
    look("R9 refill from start", key_of(9), 1'b1, sub_of(9), 1'b0);
    // R1: reset in mid-run empties the table
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    look("R1 reset empties table", key_of(9), 1'b0, key_of(9)[COL_W-1:0], 1'b0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    wait (cycles > 20000);
    if (!done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL watchdog: run did not finish, got %0d cycles expected fewer", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule